// File: doc/BRIEF.md
# HDLC Channel FIFO Status Register

This block keeps the 8-bit status word of one HDLC channel. The channel has a 128-byte receive FIFO and a 128-byte transmit FIFO. The FIFO storage, the framer and the CRC logic sit outside the block. The block receives the two FIFO occupancy counts, a programmable receive high-watermark and a programmable transmit low-watermark. It also receives single-cycle event pulses from the framer. From these inputs it builds two kinds of status bit.

Three bits are sticky event flags. One records that a transmit message has finished. One records that a receive packet has opened. One records that a receive packet has ended, whether it ended cleanly or through a fault. A CPU read returns the whole word and clears these three flags. Four bits are live conditions, registered once per cycle from the fill counts and the watermarks. A read does not change them.

A read presents the word held in the register during the read cycle. The clear takes effect at the next clock edge. If an event pulse arrives in the same cycle as the read, the event is not lost.

Top module: `hdlc_fifo_status`

## Requirements
- R1: While reset is active (rst_n low, asynchronous), every bit of rd_data is 0.
- R2: Bit 7 of rd_data always reads 0.
- R3: A pulse on rx_open_flag sets bit 4 at the next clock edge.
- R4: A pulse on any of rx_good_end, rx_crc_err, rx_overrun or rx_abort sets bit 5 at the next clock edge.
- R5: A pulse on tx_msg_done sets bit 6 at the next clock edge.
- R6: In a cycle with rd_en high, rd_data shows the value held before that cycle. Event bits 6:4 then clear at the next edge unless their own event arrives in that cycle.
- R7: An event pulse that arrives in the same cycle as a read leaves its bit set after the read.
- R8: Bit 3 is 1 exactly when rx_count was strictly greater than rx_high_mark at the previous clock edge.
- R9: Bit 2 is 1 exactly when rx_count was non-zero at the previous clock edge.
- R10: Bit 1 is 1 exactly when tx_count was strictly less than tx_low_mark at the previous clock edge.
- R11: Bit 0 is 1 exactly when tx_count was below the FIFO depth (128) at the previous clock edge.
- R12: Without a read, a set event bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_count | input | 8 | Receive FIFO occupancy in bytes (0..128) |
| tx_count | input | 8 | Transmit FIFO occupancy in bytes (0..128) |
| rx_high_mark | input | 8 | Receive high-watermark threshold |
| tx_low_mark | input | 8 | Transmit low-watermark threshold |
| rx_open_flag | input | 1 | Pulse: opening flag seen on receive |
| rx_good_end | input | 1 | Pulse: receive packet ended with a good CRC |
| rx_crc_err | input | 1 | Pulse: receive packet ended with a CRC error |
| rx_overrun | input | 1 | Pulse: receive FIFO overrun |
| rx_abort | input | 1 | Pulse: abort sequence seen on receive |
| tx_msg_done | input | 1 | Pulse: transmitter finished a message |
| rd_en | input | 1 | CPU read strobe; clears event bits 6:4 |
| rd_data | output | 8 | Status word |

## Verification
The bound checker enforces several rules on every cycle. Bit 7 must stay zero. Each event pulse must set its bit on the next edge. A read with no coincident event must clear the bit. With no read, a set bit must hold. Each of the four live bits must follow its comparison of the previous cycle. The bench scenarios cover what the per-cycle rules cannot show: the exact word a read returns when an event and a read collide, and the OR-merge of all four receive end causes into one flag. They also exercise the watermark boundaries at equality and the full and empty FIFO limits, which the bench drives deliberately.

// File: rtl/hdlc_fifo_status.sv
`timescale 1ns/1ps
module hdlc_fifo_status #(
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_high_mark,
  input  logic [CW-1:0] tx_low_mark,
  input  logic          rx_open_flag,
  input  logic          rx_good_end,
  input  logic          rx_crc_err,
  input  logic          rx_overrun,
  input  logic          rx_abort,
  input  logic          tx_msg_done,
  input  logic          rd_en,
  output logic [7:0]    rd_data
);

  logic [2:0] ev_q;
  logic [3:0] live_q;

  wire       rx_end = rx_good_end | rx_crc_err | rx_overrun | rx_abort;
  wire [2:0] ev_set = {tx_msg_done, rx_end, rx_open_flag};

  wire [3:0] live_d = {rx_count > rx_high_mark,
                       rx_count != '0,
                       tx_count < tx_low_mark,
                       tx_count < CW'(DEPTH)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      live_q <= '0;
    end else begin
      ev_q   <= (rd_en ? 3'b000 : ev_q) | ev_set;
      live_q <= live_d;
    end
  end

  assign rd_data = {1'b0, ev_q, live_q};

endmodule

// File: rtl/hdlc_fifo_status_chk.sv
`timescale 1ns/1ps
module hdlc_fifo_status_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_high_mark,
  input logic [CW-1:0] tx_low_mark,
  input logic          rx_open_flag,
  input logic          rx_good_end,
  input logic          rx_crc_err,
  input logic          rx_overrun,
  input logic          rx_abort,
  input logic          tx_msg_done,
  input logic          rd_en,
  input logic [7:0]    rd_data,
  input logic [CW-1:0] depth_val
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  wire any_end = rx_good_end | rx_crc_err | rx_overrun | rx_abort;

  assert_bit7_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] == 1'b0);

  assert_open_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_open_flag |=> rd_data[4]);

  assert_end_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_end |=> rd_data[5]);

  assert_done_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_msg_done |=> rd_data[6]);

  assert_read_clears_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rx_open_flag) |=> !rd_data[4]);

  assert_read_clears_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !any_end) |=> !rd_data[5]);

  assert_read_clears_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !tx_msg_done) |=> !rd_data[6]);

  assert_event_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && rd_data[6:4] != 3'b000) |=> ((rd_data[6:4] & $past(rd_data[6:4])) == $past(rd_data[6:4])));

  assert_rx_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> rd_data[3] == $past(rx_count > rx_high_mark));

  assert_rx_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> rd_data[2] == $past(rx_count != '0));

  assert_tx_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> rd_data[1] == $past(tx_count < tx_low_mark));

  assert_tx_notfull_R11: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> rd_data[0] == $past(tx_count < depth_val));

endmodule

bind hdlc_fifo_status hdlc_fifo_status_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
  .rx_high_mark(rx_high_mark), .tx_low_mark(tx_low_mark),
  .rx_open_flag(rx_open_flag), .rx_good_end(rx_good_end),
  .rx_crc_err(rx_crc_err), .rx_overrun(rx_overrun), .rx_abort(rx_abort),
  .tx_msg_done(tx_msg_done), .rd_en(rd_en), .rd_data(rd_data),
  .depth_val(CW'(DEPTH))
);

// File: tb/test_hdlc_fifo_status.sv
`timescale 1ns/1ps
module test_hdlc_fifo_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_count = 8'd0, tx_count = 8'd0;
  logic [7:0] rx_high_mark = 8'd100, tx_low_mark = 8'd16;
  logic       rx_open_flag = 0, rx_good_end = 0, rx_crc_err = 0;
  logic       rx_overrun = 0, rx_abort = 0, tx_msg_done = 0, rd_en = 0;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  hdlc_fifo_status i_hdlc_fifo_status (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
    .rx_high_mark(rx_high_mark), .tx_low_mark(tx_low_mark),
    .rx_open_flag(rx_open_flag), .rx_good_end(rx_good_end),
    .rx_crc_err(rx_crc_err), .rx_overrun(rx_overrun), .rx_abort(rx_abort),
    .tx_msg_done(tx_msg_done), .rd_en(rd_en), .rd_data(rd_data)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  // driver: issue a read and push the expected word to the scoreboard
  task automatic rd(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1;
    cyc();
    rd_en = 1'b0;
  endtask

  // monitor: compare every read against the scoreboard head
  always @(negedge clk) begin
    if (rd_en && !done) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %02h expected none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: actual %02h expected %02h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) cyc();
    rd(8'h00, "R1 reset");
    rst_n = 1'b1;
    cyc();
    // idle: tx empty, below low mark and not full (R10, R11), bit7 zero (R2)
    rd(8'h03, "R10 R11 R2 idle");

    // R3 open flag, R6 clear on read
    rx_open_flag = 1; cyc(); rx_open_flag = 0;
    rd(8'h13, "R3 open");
    rd(8'h03, "R6 cleared");

    // R4: each end cause
    rx_good_end = 1; cyc(); rx_good_end = 0;
    rd(8'h23, "R4 good end");
    rd(8'h03, "R6 cleared");
    rx_crc_err = 1; cyc(); rx_crc_err = 0;
    rd(8'h23, "R4 crc error");
    rx_overrun = 1; cyc(); rx_overrun = 0;
    rd(8'h23, "R4 overrun");
    rx_abort = 1; cyc(); rx_abort = 0;
    rd(8'h23, "R4 abort");
    rd(8'h03, "R6 cleared");

    // R5 tx done
    tx_msg_done = 1; cyc(); tx_msg_done = 0;
    rd(8'h43, "R5 tx done");
    rd(8'h03, "R6 cleared");

    // R12 persistence without read
    rx_open_flag = 1; cyc(); rx_open_flag = 0;
    repeat (6) cyc();
    rd(8'h13, "R12 hold");

    // R7 event during read: returns old value, new event kept
    rx_open_flag = 1; cyc(); rx_open_flag = 0;
    rx_good_end = 1;
    rd(8'h13, "R6 R7 read returns prior");
    rx_good_end = 0;
    rd(8'h23, "R7 coincident end kept");
    rx_open_flag = 1; cyc();
    rd(8'h13, "R7 same bit during read");
    rx_open_flag = 0;
    rd(8'h13, "R7 same bit kept");
    rd(8'h03, "R6 cleared");

    // all events at once (R2 bit7 stays 0)
    rx_open_flag = 1; rx_abort = 1; tx_msg_done = 1; cyc();
    rx_open_flag = 0; rx_abort = 0; tx_msg_done = 0;
    rd(8'h73, "R2 R3 R4 R5 all events");

    // R9 / R8 receive fill
    rx_count = 8'd1; cyc();
    rd(8'h07, "R9 one byte");
    rx_count = 8'd100; cyc();
    rd(8'h07, "R8 equal mark not above");
    rx_count = 8'd101; cyc();
    rd(8'h0F, "R8 above mark");
    rx_count = 8'd128; cyc();
    rd(8'h0F, "R8 R9 full");
    rx_high_mark = 8'd0; rx_count = 8'd1; cyc();
    rd(8'h0F, "R8 mark zero");
    rx_high_mark = 8'd100; rx_count = 8'd0; cyc();
    rd(8'h03, "R9 empty");

    // R10 / R11 transmit fill
    tx_count = 8'd15; cyc();
    rd(8'h03, "R10 below mark");
    tx_count = 8'd16; cyc();
    rd(8'h01, "R10 equal mark");
    tx_count = 8'd127; cyc();
    rd(8'h01, "R11 one free");
    tx_count = 8'd128; cyc();
    rd(8'h00, "R11 full");
    tx_low_mark = 8'd0; tx_count = 8'd0; cyc();
    rd(8'h01, "R10 mark zero");

    // live bits unaffected by a read, event set while live change
    tx_low_mark = 8'd16;
    rx_count = 8'd120; tx_msg_done = 1; cyc(); tx_msg_done = 0;
    rd(8'h4F, "R5 R8 R9 mixed");
    rd(8'h0F, "R6 live kept");

    // R1 asynchronous reset mid-run
    rx_open_flag = 1; cyc(); rx_open_flag = 0;
    rst_n = 1'b0; #1;
    rd(8'h00, "R1 reset clears");

    cyc();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule